// File: doc/BRIEF.md
# Transmit Descriptor Ring Walker

This block is the transmit side of a packet DMA engine. After a poll strobe it walks a ring of 32-byte descriptors held in system memory. Each descriptor is taken only when the engine owns it. The engine checks the buffer sizes, streams the buffer bytes toward the MAC on a valid/ready byte interface, hands the descriptor back to software by clearing its ownership bit, and moves to the next descriptor. Descriptor reads, the write-back and buffer reads all go through one request/acknowledge memory port, which carries one 32-bit word per access.

A descriptor places its control/status word at byte offset 0. Offset 4 holds the two size fields: buffer 1 in bits 11:0 and buffer 2 in bits 27:16. Offset 8 holds the buffer-1 address. The remaining words are never touched. In the control/status word, bit 31 is ownership, bit 29 marks the last buffer of a frame and bit 21 marks the end of the ring. The ring has no length setting: the end-of-ring flag in a descriptor sends the pointer back to the base address. A malformed descriptor ends the walk with no error report.

Top module: `txring_walker`

## Requirements
- R1: After reset the engine is idle (`busy_o` low) with no memory request, no valid byte and no event pulse.
- R2: A descriptor whose control/status bit 31 is clear ends the walk. The engine returns to idle with no write-back and no byte sent.
- R3: The walk stops silently, with no write-back and no byte sent for that descriptor, when the buffer-1 size (bits 11:0 of word 1) is above 2048 or the buffer-2 size (bits 27:16 of word 1) is nonzero.
- R4: Buffer bytes leave in increasing address order, byte lane 0 of each 32-bit word first, from any start alignment. A zero-length buffer sends no byte.
- R5: `tx_last_o` is high only on the final byte of a descriptor whose bit 29 is set. While `tx_ready_i` is low, the offered byte and `tx_last_o` stay unchanged.
- R6: After streaming, word 0 is written back to the descriptor's own address with bit 31 cleared and all other bits unchanged. No other descriptor word is written.
- R7: After a write-back, the current pointer reloads from `base_addr_i` when bit 21 is set. Otherwise it advances by 32.
- R8: When a descriptor with bit 29 set is written back, `frame_done_o` and `norm_sum_o` each pulse high for exactly one cycle.
- R9: The frame length is accumulated over the descriptors of one frame. When adding a buffer would bring it to 8192 bytes or more, the walk aborts before that buffer is streamed or written back.
- R10: A poll that arrives while the engine is busy is remembered. Exactly one further walk starts after the engine has been idle for one cycle.
- R11: `base_load_i` copies `base_addr_i` into the current pointer only while the engine is idle. While busy it is ignored.
- R12: A memory request holds its address and direction unchanged until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| poll_i | input | 1 | Poll-demand strobe |
| base_load_i | input | 1 | Load current pointer from base (idle only) |
| base_addr_i | input | AW | Ring base byte address |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | AW | Word-aligned byte address |
| mem_wdata_o | output | 32 | Write data |
| mem_ack_i | input | 1 | Memory acknowledge; read data valid |
| mem_rdata_i | input | 32 | Read data |
| tx_valid_o | output | 1 | Byte valid toward MAC |
| tx_data_o | output | 8 | Byte toward MAC |
| tx_last_o | output | 1 | Final byte of frame |
| tx_ready_i | input | 1 | MAC accepts byte |
| busy_o | output | 1 | Engine walking |
| frame_done_o | output | 1 | Frame completed pulse |
| norm_sum_o | output | 1 | Normal summary event pulse |

## Verification
A wrong pointer shows up on the memory port one access after the next write-back: the following control-word read or write-back goes to the wrong address. A wrong byte counter or byte lane shows up in the first misordered byte, or as a missing or misplaced `tx_last_o` within one buffer. A wrong frame accumulator shows up as a missing abort or a spurious one when the fourth 2048-byte buffer of a frame is reached. A lost or duplicated pending poll shows up as the wrong number of rising edges on `busy_o`.

// File: rtl/txring_walker.sv
module txring_walker #(
  parameter int AW         = 32,
  parameter int MAX_BUF    = 2048,
  parameter int MAX_FRAME  = 8192,
  parameter int DESC_BYTES = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          poll_i,
  input  logic          base_load_i,
  input  logic [AW-1:0] base_addr_i,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [31:0]   mem_wdata_o,
  input  logic          mem_ack_i,
  input  logic [31:0]   mem_rdata_i,
  output logic          tx_valid_o,
  output logic [7:0]    tx_data_o,
  output logic          tx_last_o,
  input  logic          tx_ready_i,
  output logic          busy_o,
  output logic          frame_done_o,
  output logic          norm_sum_o
);
  localparam int FW = $clog2(MAX_FRAME + MAX_BUF + 1);
  localparam logic [11:0] MAXB = 12'(MAX_BUF);
  localparam logic [FW:0] MAXF = (FW+1)'(MAX_FRAME);
  localparam int OWN = 31, LAST = 29, EOR = 21;

  typedef enum logic [2:0] {S_IDLE, S_CTL, S_SIZE, S_ADDR, S_FILL, S_SEND, S_WB} st_t;
  st_t st;

  logic [AW-1:0] cur, bptr;
  logic [31:0]   ctl, word;
  logic [11:0]   rem;
  logic [FW-1:0] fsz;
  logic          pend, done_q;

  wire [11:0] len1 = mem_rdata_i[11:0];
  wire [11:0] len2 = mem_rdata_i[27:16];
  wire [FW:0] fsum = {1'b0, fsz} + (FW+1)'(len1);
  wire        bad  = (len1 > MAXB) || (len2 != 12'd0) || (fsum >= MAXF);

  assign busy_o      = st != S_IDLE;
  assign mem_req_o   = st inside {S_CTL, S_SIZE, S_ADDR, S_FILL, S_WB};
  assign mem_we_o    = st == S_WB;
  assign mem_wdata_o = {1'b0, ctl[30:0]};
  assign tx_valid_o  = st == S_SEND;
  assign tx_data_o   = word[{bptr[1:0], 3'b000} +: 8];
  assign tx_last_o   = tx_valid_o && ctl[LAST] && rem == 12'd1;
  assign frame_done_o = done_q;
  assign norm_sum_o   = done_q;

  always_comb begin
    case (st)
      S_SIZE:  mem_addr_o = cur + AW'(4);
      S_ADDR:  mem_addr_o = cur + AW'(8);
      S_FILL:  mem_addr_o = {bptr[AW-1:2], 2'b00};
      default: mem_addr_o = cur;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      cur    <= '0;
      bptr   <= '0;
      ctl    <= '0;
      word   <= '0;
      rem    <= '0;
      fsz    <= '0;
      pend   <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= st == S_WB && mem_ack_i && ctl[LAST];
      if (st != S_IDLE && poll_i) pend <= 1'b1;
      case (st)
        S_IDLE: begin
          if (base_load_i) cur <= base_addr_i;
          if (poll_i || pend) begin
            st   <= S_CTL;
            pend <= 1'b0;
            fsz  <= '0;
          end
        end
        S_CTL: if (mem_ack_i) begin
          ctl <= mem_rdata_i;
          st  <= mem_rdata_i[OWN] ? S_SIZE : S_IDLE;
        end
        S_SIZE: if (mem_ack_i) begin
          if (bad) st <= S_IDLE;
          else begin
            rem <= len1;
            fsz <= fsum[FW-1:0];
            st  <= S_ADDR;
          end
        end
        S_ADDR: if (mem_ack_i) begin
          bptr <= mem_rdata_i[AW-1:0];
          st   <= (rem == 12'd0) ? S_WB : S_FILL;
        end
        S_FILL: if (mem_ack_i) begin
          word <= mem_rdata_i;
          st   <= S_SEND;
        end
        S_SEND: if (tx_ready_i) begin
          rem  <= rem - 12'd1;
          bptr <= bptr + AW'(1);
          if (rem == 12'd1)          st <= S_WB;
          else if (bptr[1:0] == 2'd3) st <= S_FILL;
        end
        S_WB: if (mem_ack_i) begin
          cur <= ctl[EOR] ? base_addr_i : cur + AW'(DESC_BYTES);
          if (ctl[LAST]) fsz <= '0;
          st <= S_CTL;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/txring_walker_chk.sv
module txring_walker_chk #(parameter int AW = 32) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_req_o,
  input logic          mem_we_o,
  input logic [AW-1:0] mem_addr_o,
  input logic [31:0]   mem_wdata_o,
  input logic          mem_ack_i,
  input logic          tx_valid_o,
  input logic [7:0]    tx_data_o,
  input logic          tx_last_o,
  input logic          tx_ready_i,
  input logic          busy_o,
  input logic          frame_done_o,
  input logic          norm_sum_o
);
  assert_req_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o));

  assert_stream_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid_o && !tx_ready_i |=> tx_valid_o && $stable(tx_data_o) && $stable(tx_last_o));

  assert_last_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_last_o |-> tx_valid_o);

  assert_wb_owner_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o && mem_we_o |-> !mem_wdata_o[31]);

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done_o |=> !frame_done_o);

  assert_sum_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    norm_sum_o |=> !norm_sum_o);

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !mem_req_o && !tx_valid_o);
endmodule

bind txring_walker txring_walker_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_req_o(mem_req_o), .mem_we_o(mem_we_o),
  .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o), .mem_ack_i(mem_ack_i),
  .tx_valid_o(tx_valid_o), .tx_data_o(tx_data_o), .tx_last_o(tx_last_o),
  .tx_ready_i(tx_ready_i), .busy_o(busy_o), .frame_done_o(frame_done_o),
  .norm_sum_o(norm_sum_o)
);

// File: tb/txring_walker_tb.sv
module txring_walker_tb;
  logic clk = 0, rst_n = 0, poll = 0, bload = 0, ack = 0, rdy = 1;
  logic [31:0] base = 32'h100, rdata = 0;
  logic req, we, tv, tl, busy, fdone, nsum;
  logic [31:0] addr, wdata;
  logic [7:0] td;

  txring_walker u_dut (
    .clk(clk), .rst_n(rst_n), .poll_i(poll), .base_load_i(bload), .base_addr_i(base),
    .mem_req_o(req), .mem_we_o(we), .mem_addr_o(addr), .mem_wdata_o(wdata),
    .mem_ack_i(ack), .mem_rdata_i(rdata), .tx_valid_o(tv), .tx_data_o(td),
    .tx_last_o(tl), .tx_ready_i(rdy), .busy_o(busy), .frame_done_o(fdone),
    .norm_sum_o(nsum));

  always #10 clk = ~clk;

  localparam int OWN = 32'h8000_0000, LST = 32'h2000_0000, EOR = 32'h0020_0000;
  localparam logic [15:0] VEC [6] = '{
    {12'd1, 2'd0, 2'd0}, {12'd4, 2'd0, 2'd1}, {12'd5, 2'd3, 2'd1},
    {12'd64, 2'd1, 2'd2}, {12'd2048, 2'd2, 2'd0}, {12'd0, 2'd0, 2'd0}};

  logic [31:0] mem [2048];
  logic [7:0]  cap [8192];
  logic [31:0] wblog [8];
  int ncap, nlast, lastidx, nwb, ndone, nsum_c, nwalks, cyc, checks, fails, rmode;
  logic pbusy;

  function automatic logic [7:0] fb(input logic [31:0] a);
    return 8'((a * 7 + 3) & 32'hff);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) ack <= 0;
    else begin
      ack <= req && !ack;
      if (req && !ack) begin
        rdata <= mem[(addr >> 2) & 32'h7ff];
        if (we) begin
          mem[(addr >> 2) & 32'h7ff] <= wdata;
          if (nwb < 8) wblog[nwb] = addr;
          nwb = nwb + 1;
        end
      end
    end
    if (tv && rdy) begin
      cap[ncap] = td;
      if (tl) begin nlast = nlast + 1; lastidx = ncap; end
      ncap = ncap + 1;
    end
    if (fdone) ndone = ndone + 1;
    if (nsum) nsum_c = nsum_c + 1;
    if (busy && !pbusy) nwalks = nwalks + 1;
    pbusy <= busy;
  end

  always @(negedge clk) begin
    cyc = cyc + 1;
    case (rmode)
      1: rdy <= cyc[0];
      2: rdy <= (cyc % 3) == 0;
      default: rdy <= 1;
    endcase
    if (cyc >= 190000) begin
      fails = fails + 1;
      $display("FAIL watchdog actual=%0d expected<190000", cyc);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks = checks + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clr();
    ncap = 0; nlast = 0; lastidx = -1; nwb = 0; ndone = 0; nsum_c = 0; nwalks = 0;
  endtask

  task automatic desc(input int a, input int c, input int sz, input int b);
    mem[a >> 2] = c; mem[(a >> 2) + 1] = sz; mem[(a >> 2) + 2] = b;
  endtask

  task automatic do_poll();
    @(negedge clk) poll = 1;
    @(negedge clk) poll = 0;
  endtask

  task automatic wait_idle();
    int n = 0;
    while (n < 4) begin
      @(negedge clk);
      if (busy) n = 0; else n = n + 1;
    end
  endtask

  task automatic load_base(input logic [31:0] b);
    base = b;
    @(negedge clk) bload = 1;
    @(negedge clk) bload = 0;
  endtask

  function automatic int byte_errs(input int from, input int n, input logic [31:0] ba);
    int e = 0;
    for (int j = 0; j < n; j++) if (cap[from + j] !== fb(ba + j)) e++;
    return e;
  endfunction

  initial begin
    checks = 0; fails = 0; cyc = 0; rmode = 0; pbusy = 0;
    clr();
    for (int i = 0; i < 2048; i++)
      mem[i] = {fb(4*i+3), fb(4*i+2), fb(4*i+1), fb(4*i)};
    for (int i = 64; i < 128; i++) mem[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(!busy && !req && !tv && !fdone && !nsum, "R1 reset idle", {busy, req, tv, fdone}, 0);
    load_base(32'h100);

    // table of vectors: R4 R5 R6 R7 R8
    for (int v = 0; v < 6; v++) begin
      int len, off, ctl;
      len = int'(VEC[v][15:4]); off = int'(VEC[v][3:2]); rmode = int'(VEC[v][1:0]);
      ctl = OWN | LST | EOR | 32'h0000_0300;
      desc(32'h100, ctl, len, 32'h1000 + off);
      clr(); do_poll(); wait_idle();
      chk(ncap == len, "R4 byte count", ncap, len);
      chk(byte_errs(0, len, 32'h1000 + off) == 0, "R4 byte order", byte_errs(0, len, 32'h1000 + off), 0);
      chk(nlast == (len > 0 ? 1 : 0) && lastidx == len - 1, "R5 last position", lastidx, len - 1);
      chk(mem[64] == (ctl & ~OWN), "R6 writeback word", mem[64], ctl & ~OWN);
      chk(nwb == 1 && wblog[0] == 32'h100, "R7 wrap to base", nwb, 1);
      chk(ndone == 1 && nsum_c == 1, "R8 event pulses", ndone, 1);
    end
    rmode = 0;

    // R2 not owned
    desc(32'h100, LST | EOR, 8, 32'h1000);
    clr(); do_poll(); wait_idle();
    chk(nwb == 0 && ncap == 0 && ndone == 0, "R2 not owned stops", nwb + ncap, 0);

    // R3 buffer-1 too large
    desc(32'h100, OWN | LST | EOR, 2049, 32'h1000);
    clr(); do_poll(); wait_idle();
    chk(nwb == 0 && ncap == 0 && mem[64] == (OWN | LST | EOR), "R3 buf1 over 2048", nwb + ncap, 0);
    // R3 buffer-2 nonzero
    desc(32'h100, OWN | LST | EOR, 32'h0001_000a, 32'h1000);
    clr(); do_poll(); wait_idle();
    chk(nwb == 0 && ncap == 0, "R3 buf2 nonzero", nwb + ncap, 0);
    mem[64] = 0;

    // two-descriptor frame: R5 R7 advance
    rmode = 1;
    desc(32'h100, OWN, 3, 32'h1000);
    desc(32'h120, OWN | LST | EOR, 5, 32'h1101);
    clr(); do_poll(); wait_idle();
    chk(ncap == 8 && byte_errs(0, 3, 32'h1000) == 0 && byte_errs(3, 5, 32'h1101) == 0,
        "R4 two buffers", ncap, 8);
    chk(nlast == 1 && lastidx == 7, "R5 last on final buffer only", lastidx, 7);
    chk(nwb == 2 && wblog[1] == 32'h120, "R7 advance by 32", wblog[1], 32'h120);
    chk(ndone == 1, "R8 one pulse per frame", ndone, 1);
    rmode = 0;

    // R9 frame length abort
    desc(32'h100, OWN, 2048, 32'h1000);
    desc(32'h120, OWN, 2048, 32'h1000);
    desc(32'h140, OWN, 2048, 32'h1000);
    desc(32'h160, OWN | LST | EOR, 2048, 32'h1000);
    clr(); do_poll(); wait_idle();
    chk(ncap == 6144 && nwb == 3, "R9 abort at 8192", ncap, 6144);
    chk(mem[88] == (OWN | LST | EOR) && ndone == 0, "R9 no writeback of aborting desc", mem[88], OWN | LST | EOR);
    for (int i = 64; i < 128; i++) mem[i] = 0;
    load_base(32'h100);

    // R10 pending poll
    desc(32'h100, OWN | LST | EOR, 40, 32'h1000);
    clr(); do_poll();
    repeat (5) @(negedge clk);
    chk(busy == 1, "R10 busy during walk", busy, 1);
    do_poll(); wait_idle();
    chk(nwalks == 2 && nwb == 1, "R10 one extra walk", nwalks, 2);
    clr(); do_poll(); wait_idle();
    chk(nwalks == 1, "R10 no extra without pending", nwalks, 1);

    // R11 base load ignored while busy
    desc(32'h100, OWN | LST, 40, 32'h1000);
    clr(); do_poll();
    base = 32'h400;
    @(negedge clk) bload = 1;
    @(negedge clk) bload = 0;
    wait_idle();
    base = 32'h100;
    desc(32'h120, OWN | LST | EOR, 1, 32'h1000);
    clr(); do_poll(); wait_idle();
    chk(nwb == 1 && wblog[0] == 32'h120, "R11 load ignored when busy", wblog[0], 32'h120);
    // R11 load while idle
    desc(32'h140, OWN | LST | EOR, 1, 32'h1000);
    load_base(32'h140);
    clr(); do_poll(); wait_idle();
    chk(nwb == 1 && wblog[0] == 32'h140, "R11 load while idle", wblog[0], 32'h140);
    chk(!busy && !req && !tv, "R1 idle after walks", {busy, req, tv}, 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule